// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block picks, once per clock, which of several hardware thread contexts may issue into a pipeline that all of them share. Each thread reports whether it is ready. The block answers with a registered thread number, an issue-valid strobe and the program counter that goes with that issue. Every context keeps its own program counter. That counter steps forward by a fixed amount each time its thread issues.

A single mode input chooses between two switching policies. The interleaved policy rotates among the ready threads on every cycle. The block-switching policy stays with one thread until that thread reports a costly stall. When it then moves to another thread, it raises a one-cycle flush request. It then holds issue off for a parameterised number of refill cycles so the pipeline can drain and restart.

Top module: `thread_select_unit`

## Requirements
- R1: While reset is high, the outputs become sel_tid=0, issue_vld=0, flush_req=0 and issue_pc=0 on the next clock edge. Each thread's program counter returns to thread_index*PC_STRIDE.
- R2: With coarse_mode=0 (interleaved), the thread that issues is the first ready one found while stepping upward, with wrap-around, from the thread after the last selected one. Bit t of thr_ready belongs to thread t, and 1 means ready. Threads that are not ready are skipped.
- R3: With coarse_mode=0 and no thread ready, issue_vld is low and sel_tid keeps its value.
- R4: With coarse_mode=0, long_stall has no effect and flush_req stays low.
- R5: With coarse_mode=1 (block switching), the selected thread issues on every cycle in which it is ready. A cleared ready bit without long_stall lowers issue_vld and keeps the same thread selected.
- R6: With coarse_mode=1 and long_stall high, the block switches if another thread is ready. It selects the first ready thread after the current one in wrap-around order, raises flush_req for exactly one cycle and does not issue in that cycle.
- R7: After such a flush, issue_vld stays low for REFILL_CYCLES further cycles, and long_stall is ignored during that window.
- R8: With coarse_mode=1, a long_stall while no other thread is ready keeps the current thread selected, with issue_vld low and no flush.
- R9: On each issue, issue_pc is the selected thread's program counter before it is advanced. That thread's counter then grows by PC_STEP, and the other threads' counters do not change.
- R10: Returning to coarse_mode=0 during a refill window abandons that window, and issue resumes at once.
- R11: All outputs respond to the inputs sampled at a clock edge and appear right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coarse_mode | input | 1 | 0 = interleave every cycle, 1 = switch only on a long stall |
| thr_ready | input | N_THREADS | Per-thread ready flags, bit t for thread t |
| long_stall | input | 1 | Costly stall reported by the selected thread |
| sel_tid | output | $clog2(N_THREADS) | Selected thread number |
| issue_vld | output | 1 | An instruction from sel_tid issues this cycle |
| flush_req | output | 1 | One-cycle pipeline flush on a block switch |
| issue_pc | output | PC_W | Program counter of the issuing thread |

## Verification
Every output is one register away from the inputs. The bench therefore drives a stimulus just after a falling edge and reads the result at the next falling edge, one rising edge later. A flush shows up one cycle after the long stall that causes it. The refill window then covers the following REFILL_CYCLES reads, and issue returns on the read after those. The table rows and the directed cases are laid out so that each row's expected values belong to exactly that one cycle.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

  typedef enum logic {
    POLICY_INTERLEAVE = 1'b0,
    POLICY_BLOCK      = 1'b1
  } policy_e;

  // Wrap-around step through a ring of n entries.
  function automatic int ring_step(input int base, input int off, input int n);
    int r;
    r = base + off;
    if (r >= n) r = r - n;
    return r;
  endfunction

endpackage

// File: rtl/tsu_rr_pick.sv
module tsu_rr_pick #(
  parameter int N_THREADS = 4,
  parameter int TID_W     = 2
) (
  input  logic [N_THREADS-1:0] req,
  input  logic [TID_W-1:0]     cur,
  output logic                 hit_any,
  output logic                 hit_other,
  output logic [TID_W-1:0]     pick
);
  import tsu_pkg::*;

  // Scan from the farthest offset down to the nearest so that the nearest
  // ready thread after cur is the one left in pick. Offset N_THREADS is cur.
  always_comb begin
    hit_any = 1'b0;
    pick    = cur;
    for (int off = N_THREADS; off >= 1; off--) begin
      int idx;
      idx = ring_step(int'(cur), off, N_THREADS);
      if (req[idx]) begin
        hit_any = 1'b1;
        pick    = TID_W'(idx);
      end
    end
  end

  assign hit_other = hit_any && (pick != cur);

endmodule

// File: rtl/tsu_pc_bank.sv
module tsu_pc_bank #(
  parameter int N_THREADS = 4,
  parameter int TID_W     = 2,
  parameter int PC_W      = 16,
  parameter int PC_STEP   = 4,
  parameter int PC_STRIDE = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_en,
  input  logic [TID_W-1:0] inc_tid,
  input  logic [TID_W-1:0] rd_tid,
  output logic [PC_W-1:0]  rd_pc
);
  logic [N_THREADS-1:0][PC_W-1:0] pc_vec;

  for (genvar t = 0; t < N_THREADS; t++) begin : g_ctx
    logic [PC_W-1:0] pc_r;
    always_ff @(posedge clk) begin
      if (rst)
        pc_r <= PC_W'(t * PC_STRIDE);
      else if (inc_en && (inc_tid == TID_W'(t)))
        pc_r <= pc_r + PC_W'(PC_STEP);
    end
    assign pc_vec[t] = pc_r;
  end

  always_comb begin
    rd_pc = '0;
    for (int t = 0; t < N_THREADS; t++)
      if (rd_tid == TID_W'(t)) rd_pc = pc_vec[t];
  end

endmodule

// File: rtl/tsu_refill_ctr.sv
module tsu_refill_ctr #(
  parameter int REFILL_CYCLES = 3,
  parameter int CNT_W         = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic clear,
  output logic busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt_q <= '0;
    else if (load)
      cnt_q <= CNT_W'(REFILL_CYCLES);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/thread_select_unit.sv
module thread_select_unit #(
  parameter int N_THREADS     = 4,
  parameter int PC_W          = 16,
  parameter int PC_STEP       = 4,
  parameter int PC_STRIDE     = 4096,
  parameter int REFILL_CYCLES = 3,
  localparam int TID_W        = $clog2(N_THREADS),
  localparam int CNT_W        = $clog2(REFILL_CYCLES + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 coarse_mode,
  input  logic [N_THREADS-1:0] thr_ready,
  input  logic                 long_stall,
  output logic [TID_W-1:0]     sel_tid,
  output logic                 issue_vld,
  output logic                 flush_req,
  output logic [PC_W-1:0]      issue_pc
);
  import tsu_pkg::*;

  policy_e          policy;
  logic             hit_any, hit_other;
  logic [TID_W-1:0] pick;
  logic             refill_busy;
  logic             issue_n, flush_n, load_n, clear_n;
  logic [TID_W-1:0] tid_n;
  logic [PC_W-1:0]  cand_pc;

  assign policy = policy_e'(coarse_mode);

  tsu_rr_pick #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_pick (
    .req       (thr_ready),
    .cur       (sel_tid),
    .hit_any   (hit_any),
    .hit_other (hit_other),
    .pick      (pick)
  );

  tsu_refill_ctr #(.REFILL_CYCLES(REFILL_CYCLES), .CNT_W(CNT_W)) u_refill (
    .clk   (clk),
    .rst   (rst),
    .load  (load_n),
    .clear (clear_n),
    .busy  (refill_busy)
  );

  tsu_pc_bank #(
    .N_THREADS (N_THREADS),
    .TID_W     (TID_W),
    .PC_W      (PC_W),
    .PC_STEP   (PC_STEP),
    .PC_STRIDE (PC_STRIDE)
  ) u_pcs (
    .clk     (clk),
    .rst     (rst),
    .inc_en  (issue_n),
    .inc_tid (tid_n),
    .rd_tid  (tid_n),
    .rd_pc   (cand_pc)
  );

  always_comb begin
    issue_n = 1'b0;
    flush_n = 1'b0;
    load_n  = 1'b0;
    clear_n = 1'b0;
    tid_n   = sel_tid;
    if (policy == POLICY_INTERLEAVE) begin
      clear_n = 1'b1;
      if (hit_any) begin
        issue_n = 1'b1;
        tid_n   = pick;
      end
    end else if (refill_busy) begin
      issue_n = 1'b0;
    end else if (long_stall) begin
      if (hit_other) begin
        tid_n   = pick;
        flush_n = 1'b1;
        load_n  = 1'b1;
      end
    end else begin
      issue_n = thr_ready[sel_tid];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_tid   <= '0;
      issue_vld <= 1'b0;
      flush_req <= 1'b0;
      issue_pc  <= '0;
    end else begin
      sel_tid   <= tid_n;
      issue_vld <= issue_n;
      flush_req <= flush_n;
      if (issue_n) issue_pc <= cand_pc;
    end
  end

endmodule

// File: rtl/tsu_checker.sv
module tsu_checker #(
  parameter int N_THREADS = 4,
  parameter int TID_W     = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 coarse_mode,
  input logic [N_THREADS-1:0] thr_ready,
  input logic                 long_stall,
  input logic [TID_W-1:0]     sel_tid,
  input logic                 issue_vld,
  input logic                 flush_req
);
  logic [N_THREADS-1:0] ready_q;
  always_ff @(posedge clk) ready_q <= thr_ready;

  p_issue_ready_r2: assert property (@(posedge clk) disable iff (rst)
    issue_vld |-> ready_q[sel_tid]);

  p_fine_issues_r2: assert property (@(posedge clk) disable iff (rst)
    (!coarse_mode && (thr_ready != '0)) |=> issue_vld);

  p_none_ready_r3: assert property (@(posedge clk) disable iff (rst)
    (!coarse_mode && (thr_ready == '0)) |=> (!issue_vld && $stable(sel_tid)));

  p_flush_only_coarse_r4: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> $past(coarse_mode));

  p_coarse_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (coarse_mode && !long_stall) |=> $stable(sel_tid));

  p_short_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (coarse_mode && !long_stall && !thr_ready[sel_tid]) |=> (!issue_vld && !flush_req));

  p_flush_no_issue_r6: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> !issue_vld);

  p_flush_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> !flush_req);

  p_refill_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (flush_req && coarse_mode) |=> !issue_vld);

endmodule

bind thread_select_unit tsu_checker #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .coarse_mode (coarse_mode),
  .thr_ready   (thr_ready),
  .long_stall  (long_stall),
  .sel_tid     (sel_tid),
  .issue_vld   (issue_vld),
  .flush_req   (flush_req)
);

// File: tb/sim_thread_select_unit.sv
`timescale 1ns/1ps
module sim_thread_select_unit;
  localparam int N = 4;
  localparam int NV = 23;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        coarse_mode = 1'b0;
  logic [3:0]  thr_ready = '0;
  logic        long_stall = 1'b0;
  logic [1:0]  sel_tid;
  logic        issue_vld;
  logic        flush_req;
  logic [15:0] issue_pc;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  thread_select_unit #(.N_THREADS(N), .PC_W(16), .PC_STEP(4), .PC_STRIDE(4096),
                       .REFILL_CYCLES(3)) u0 (
    .clk(clk), .rst(rst), .coarse_mode(coarse_mode), .thr_ready(thr_ready),
    .long_stall(long_stall), .sel_tid(sel_tid), .issue_vld(issue_vld),
    .flush_req(flush_req), .issue_pc(issue_pc)
  );

  // Row layout: mode | ready[3:0] | long_stall | tid[1:0] | vld | flush | pc[15:0] | req
  localparam logic [29:0] VECS [NV] = '{
    {1'b0, 4'b1111, 1'b0, 2'd1, 1'b1, 1'b0, 16'h1000, 4'd2},  // R2 R9
    {1'b0, 4'b1111, 1'b0, 2'd2, 1'b1, 1'b0, 16'h2000, 4'd2},  // R2
    {1'b0, 4'b1111, 1'b0, 2'd3, 1'b1, 1'b0, 16'h3000, 4'd2},  // R2
    {1'b0, 4'b1111, 1'b0, 2'd0, 1'b1, 1'b0, 16'h0000, 4'd2},  // R2 wrap
    {1'b0, 4'b0101, 1'b0, 2'd2, 1'b1, 1'b0, 16'h2004, 4'd2},  // R2 skip
    {1'b0, 4'b0101, 1'b0, 2'd0, 1'b1, 1'b0, 16'h0004, 4'd2},  // R2 skip
    {1'b0, 4'b0000, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0004, 4'd3},  // R3
    {1'b0, 4'b0001, 1'b0, 2'd0, 1'b1, 1'b0, 16'h0008, 4'd2},  // R2 self
    {1'b0, 4'b1000, 1'b0, 2'd3, 1'b1, 1'b0, 16'h3004, 4'd2},  // R2
    {1'b1, 4'b1111, 1'b0, 2'd3, 1'b1, 1'b0, 16'h3008, 4'd5},  // R5
    {1'b1, 4'b0111, 1'b0, 2'd3, 1'b0, 1'b0, 16'h3008, 4'd5},  // R5 short stall
    {1'b1, 4'b1111, 1'b1, 2'd0, 1'b0, 1'b1, 16'h3008, 4'd6},  // R6
    {1'b1, 4'b1111, 1'b0, 2'd0, 1'b0, 1'b0, 16'h3008, 4'd7},  // R7
    {1'b1, 4'b1111, 1'b0, 2'd0, 1'b0, 1'b0, 16'h3008, 4'd7},  // R7
    {1'b1, 4'b1111, 1'b0, 2'd0, 1'b0, 1'b0, 16'h3008, 4'd7},  // R7
    {1'b1, 4'b1111, 1'b0, 2'd0, 1'b1, 1'b0, 16'h000C, 4'd7},  // R7 resume
    {1'b1, 4'b1000, 1'b1, 2'd3, 1'b0, 1'b1, 16'h000C, 4'd6},  // R6
    {1'b1, 4'b1111, 1'b1, 2'd3, 1'b0, 1'b0, 16'h000C, 4'd7},  // R7 stall ignored
    {1'b1, 4'b1111, 1'b1, 2'd3, 1'b0, 1'b0, 16'h000C, 4'd7},  // R7
    {1'b1, 4'b1111, 1'b1, 2'd3, 1'b0, 1'b0, 16'h000C, 4'd7},  // R7
    {1'b1, 4'b1111, 1'b0, 2'd3, 1'b1, 1'b0, 16'h300C, 4'd9},  // R9
    {1'b1, 4'b1000, 1'b1, 2'd3, 1'b0, 1'b0, 16'h300C, 4'd8},  // R8
    {1'b0, 4'b1111, 1'b0, 2'd0, 1'b1, 1'b0, 16'h0010, 4'd2}   // R2 back to interleave
  };

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual tid/vld/flush/pc=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive just after a falling edge; read one rising edge later (R11).
  task automatic step(input logic m, input logic [3:0] r, input logic ls);
    coarse_mode = m;
    thr_ready   = r;
    long_stall  = ls;
    @(negedge clk);
  endtask

  function automatic logic [19:0] outs();
    return {sel_tid, issue_vld, flush_req, issue_pc};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", outs(), {2'd0, 1'b0, 1'b0, 16'h0000});
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i][29], VECS[i][28:25], VECS[i][24]);
      check($sformatf("R%0d row %0d", VECS[i][3:0], i), outs(), VECS[i][23:4]);
    end

    // R6: block switch from thread 0 to thread 1
    step(1'b1, 4'b1111, 1'b1);
    check("R6", outs(), {2'd1, 1'b0, 1'b1, 16'h0010});
    // R10: interleave during refill issues at once
    step(1'b0, 4'b1111, 1'b0);
    check("R10", outs(), {2'd2, 1'b1, 1'b0, 16'h2008});
    // R4: long stall ignored in interleave mode, no flush
    step(1'b0, 4'b1111, 1'b1);
    check("R4", outs(), {2'd3, 1'b1, 1'b0, 16'h3010});
    // R1: mid-run reset clears outputs and restores counters
    rst = 1'b1;
    @(negedge clk);
    check("R1", outs(), {2'd0, 1'b0, 1'b0, 16'h0000});
    rst = 1'b0;
    step(1'b0, 4'b1111, 1'b0);
    check("R1", outs(), {2'd1, 1'b1, 1'b0, 16'h1000});
    // R8: block mode, lone ready thread stalls long
    step(1'b1, 4'b0010, 1'b1);
    check("R8", outs(), {2'd1, 1'b0, 1'b0, 16'h1000});
    step(1'b1, 4'b0010, 1'b0);
    check("R9", outs(), {2'd1, 1'b1, 1'b0, 16'h1004});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule